// File: doc/BRIEF.md
# Incremental Line Rasterizer

This block walks a straight line one pixel at a time with the integer error-term method. Software first works out three constants: an axial step, a diagonal step and a starting error value. It then supplies them, along with a start point, a pixel count along the major axis and a command byte, and pulses `go`. From the next cycle the block presents one coordinate pair per cycle on a valid/ready output stream. A downstream pixel writer consumes these pairs.

The command byte picks which axis is the major one and which way X and Y move. It can also drop the final pixel of the line, or turn the whole command into a pure pen move that emits nothing. In every case, when the command ends the block holds the point one step beyond the last point it computed, so the next line can continue from there.

Back-pressure rules: once `pix_valid` is high it stays high, and `pix_x`/`pix_y` stay unchanged, until a cycle in which `pix_ready` is also high. A pixel counts as transferred only on a clock edge where both signals are high. The block never drops or repeats a pixel, whatever the pattern of `pix_ready`.

Top module: `vec_line_engine`

## Requirements
- R1: The first clock edge with `go` high while `busy` is low latches all inputs. If `major_len` is nonzero, `busy` is high from the next cycle. In draw mode `pix_valid` is also high from that cycle, with `pix_x`/`pix_y` equal to the start point.
- R2: Command bit 6 selects the major axis (1 = Y, 0 = X). Between consecutive emitted pixels, the major coordinate always changes by exactly one.
- R3: Command bit 5 sets the X direction (1 = increasing, 0 = decreasing). Command bit 7 sets the Y direction (1 = increasing, 0 = decreasing). Coordinates wrap modulo 2^16.
- R4: At each step, the block tests the sign of the 18-bit two's-complement error:
  - If the error is zero or positive, the minor coordinate also steps and the diagonal constant is added to the error.
  - If the error is negative, only the axial constant is added.
  The minor coordinate never moves by more than one per step.
- R5: With command bit 4 set and bit 2 clear, exactly `major_len` pixels are emitted. A `major_len` of zero emits none.
- R6: With command bit 2 set, the last of the `major_len` computed points is not emitted, so `major_len`-1 pixels appear. The step past it is still taken.
- R7: With command bit 4 clear, no pixel is emitted. `busy` is high for exactly `major_len` cycles while the position advances.
- R8: When a command finishes, `cur_x`/`cur_y` hold the point one step past the last computed point. For a zero-length command they hold the start point.
- R9: While `pix_valid` is high and `pix_ready` is low, `pix_valid` stays high and the coordinates stay stable on the next cycle.
- R10: `busy` is low whenever `pix_valid` is low for lack of work. In plain draw mode `busy` falls on the edge that transfers the final pixel. A `go` received while `busy` is high has no effect.
- R11: After reset, `busy`, `pix_valid`, `cur_x` and `cur_y` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | Start strobe; accepted only while idle |
| start_x | input | 16 | Start X coordinate |
| start_y | input | 16 | Start Y coordinate |
| axial_step | input | 18 | Error increment when only the major axis steps |
| diag_step | input | 18 | Error increment when both axes step |
| err_init | input | 18 | Initial error term |
| major_len | input | 16 | Number of points along the major axis |
| cmd_word | input | 8 | Bit 2 drop last, bit 4 draw, bit 5 X increasing, bit 6 Y major, bit 7 Y increasing |
| pix_valid | output | 1 | Pixel coordinate available |
| pix_ready | input | 1 | Consumer accepts the pixel |
| pix_x | output | 16 | Pixel X coordinate |
| pix_y | output | 16 | Pixel Y coordinate |
| busy | output | 1 | Command in progress |
| cur_x | output | 16 | Current position X after the last command |
| cur_y | output | 16 | Current position Y after the last command |

## Verification
The first pixel and `busy` are due one cycle after the edge that accepts `go`. The bench drives `go` at a falling edge and samples exactly one falling edge later. Each further pixel is due one cycle after the previous transfer. The bench re-randomizes `pix_ready` at each falling edge and compares the presented coordinate against its own computed list at that same falling edge. `busy` low and the updated current position are due one cycle after the final advancing edge, and the bench checks both on the falling edge that follows it. For move-only commands it counts the sampled busy cycles against `major_len`.

// File: rtl/line_pkg.sv
package line_pkg;

  localparam int CMD_W     = 8;
  localparam int CB_NOLAST = 2;
  localparam int CB_DRAW   = 4;
  localparam int CB_XPOS   = 5;
  localparam int CB_YMAJ   = 6;
  localparam int CB_YPOS   = 7;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } line_state_e;

  typedef struct packed {
    logic y_pos;
    logic y_major;
    logic x_pos;
    logic draw;
    logic no_last;
  } line_mode_t;

endpackage

// File: rtl/line_cmd_decode.sv
module line_cmd_decode
  import line_pkg::*;
(
  input  logic [CMD_W-1:0] cmd,
  output line_mode_t       mode
);

  // reserved command bits carry no meaning here
  logic unused_cmd_bits;
  assign unused_cmd_bits = ^{cmd[3], cmd[1:0]};

  always_comb begin
    mode.y_pos   = cmd[CB_YPOS];
    mode.y_major = cmd[CB_YMAJ];
    mode.x_pos   = cmd[CB_XPOS];
    mode.draw    = cmd[CB_DRAW];
    mode.no_last = cmd[CB_NOLAST];
  end

endmodule

// File: rtl/line_step_unit.sv
module line_step_unit
  import line_pkg::*;
#(
  parameter int CW = 16,
  parameter int EW = 18
) (
  input  logic [CW-1:0] x,
  input  logic [CW-1:0] y,
  input  logic [EW-1:0] err,
  input  logic [EW-1:0] axial,
  input  logic [EW-1:0] diag,
  input  line_mode_t    mode,
  output logic [CW-1:0] nxt_x,
  output logic [CW-1:0] nxt_y,
  output logic [EW-1:0] nxt_err
);

  localparam int SIGN = EW - 1;

  logic [CW-1:0] x_step;
  logic [CW-1:0] y_step;
  logic          minor_go;

  assign x_step   = mode.x_pos ? x + 1'b1 : x - 1'b1;
  assign y_step   = mode.y_pos ? y + 1'b1 : y - 1'b1;
  assign minor_go = ~err[SIGN];

  always_comb begin
    if (mode.y_major) begin
      nxt_y = y_step;
      nxt_x = minor_go ? x_step : x;
    end else begin
      nxt_x = x_step;
      nxt_y = minor_go ? y_step : y;
    end
    nxt_err = minor_go ? err + diag : err + axial;
  end

endmodule

// File: rtl/line_seq_ctrl.sv
module line_seq_ctrl
  import line_pkg::*;
#(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] len_in,
  input  logic          draw,
  input  logic          no_last,
  input  logic          out_ready,
  output logic          busy,
  output logic          emit,
  output logic          advance,
  output logic          finish
);

  line_state_e   state_q;
  logic [LW-1:0] rem_q;
  logic          on_last;

  assign on_last = (rem_q == {{(LW-1){1'b0}}, 1'b1});
  assign busy    = (state_q == ST_RUN);
  assign emit    = busy && draw && !(no_last && on_last);
  assign advance = busy && (!emit || out_ready);
  assign finish  = advance && on_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_RUN;
            rem_q   <= len_in;
          end
        end
        ST_RUN: begin
          if (advance) begin
            rem_q <= rem_q - 1'b1;
            if (on_last) state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/vec_line_engine.sv
module vec_line_engine
  import line_pkg::*;
#(
  parameter int CW = 16,
  parameter int EW = 18,
  parameter int LW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [CW-1:0]    start_x,
  input  logic [CW-1:0]    start_y,
  input  logic [EW-1:0]    axial_step,
  input  logic [EW-1:0]    diag_step,
  input  logic [EW-1:0]    err_init,
  input  logic [LW-1:0]    major_len,
  input  logic [CMD_W-1:0] cmd_word,
  output logic             pix_valid,
  input  logic             pix_ready,
  output logic [CW-1:0]    pix_x,
  output logic [CW-1:0]    pix_y,
  output logic             busy,
  output logic [CW-1:0]    cur_x,
  output logic [CW-1:0]    cur_y
);

  line_mode_t    mode_in;
  line_mode_t    mode_q;
  logic [CW-1:0] x_q, y_q;
  logic [EW-1:0] err_q, axial_q, diag_q;
  logic [CW-1:0] nxt_x, nxt_y;
  logic [EW-1:0] nxt_err;
  logic          accept, emit, advance, finish;
  logic          mode_draw, mode_ymaj;

  line_cmd_decode u_dec (
    .cmd  (cmd_word),
    .mode (mode_in)
  );

  assign accept = go && !busy;

  line_seq_ctrl #(.LW(LW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept && (major_len != '0)),
    .len_in    (major_len),
    .draw      (mode_q.draw),
    .no_last   (mode_q.no_last),
    .out_ready (pix_ready),
    .busy      (busy),
    .emit      (emit),
    .advance   (advance),
    .finish    (finish)
  );

  line_step_unit #(.CW(CW), .EW(EW)) u_step (
    .x       (x_q),
    .y       (y_q),
    .err     (err_q),
    .axial   (axial_q),
    .diag    (diag_q),
    .mode    (mode_q),
    .nxt_x   (nxt_x),
    .nxt_y   (nxt_y),
    .nxt_err (nxt_err)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q     <= '0;
      y_q     <= '0;
      err_q   <= '0;
      axial_q <= '0;
      diag_q  <= '0;
      mode_q  <= '0;
    end else if (accept) begin
      x_q     <= start_x;
      y_q     <= start_y;
      err_q   <= err_init;
      axial_q <= axial_step;
      diag_q  <= diag_step;
      mode_q  <= mode_in;
    end else if (advance) begin
      x_q   <= nxt_x;
      y_q   <= nxt_y;
      err_q <= nxt_err;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_x <= '0;
      cur_y <= '0;
    end else if (accept && (major_len == '0)) begin
      cur_x <= start_x;
      cur_y <= start_y;
    end else if (finish) begin
      cur_x <= nxt_x;
      cur_y <= nxt_y;
    end
  end

  assign pix_valid = emit;
  assign pix_x     = x_q;
  assign pix_y     = y_q;
  assign mode_draw = mode_q.draw;
  assign mode_ymaj = mode_q.y_major;

endmodule

// File: rtl/line_engine_chk.sv
module line_engine_chk #(
  parameter int CW = 16,
  parameter int LW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          go,
  input logic [LW-1:0] major_len,
  input logic          busy,
  input logic          pix_valid,
  input logic          pix_ready,
  input logic [CW-1:0] pix_x,
  input logic [CW-1:0] pix_y,
  input logic          mode_draw,
  input logic          mode_ymaj
);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && !pix_ready |=> pix_valid && $stable(pix_x) && $stable(pix_y));

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !pix_valid);

  p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    go && !busy && (major_len != '0) |=> busy);

  p_move_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mode_draw |-> !pix_valid);

  p_major_y_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_ready && mode_ymaj |=> !pix_valid ||
      (pix_y == $past(pix_y) + 1'b1) || (pix_y == $past(pix_y) - 1'b1));

  p_major_x_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_ready && !mode_ymaj |=> !pix_valid ||
      (pix_x == $past(pix_x) + 1'b1) || (pix_x == $past(pix_x) - 1'b1));

  p_minor_unit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid && pix_ready |=> !pix_valid ||
      (mode_ymaj ? ((pix_x == $past(pix_x)) || (pix_x == $past(pix_x) + 1'b1) ||
                    (pix_x == $past(pix_x) - 1'b1))
                 : ((pix_y == $past(pix_y)) || (pix_y == $past(pix_y) + 1'b1) ||
                    (pix_y == $past(pix_y) - 1'b1))));

endmodule

bind vec_line_engine line_engine_chk #(.CW(CW), .LW(LW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .go        (go),
  .major_len (major_len),
  .busy      (busy),
  .pix_valid (pix_valid),
  .pix_ready (pix_ready),
  .pix_x     (pix_x),
  .pix_y     (pix_y),
  .mode_draw (mode_draw),
  .mode_ymaj (mode_ymaj)
);

// File: tb/vec_line_engine_test.sv
module vec_line_engine_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        go = 1'b0;
  logic [15:0] start_x = '0, start_y = '0;
  logic [17:0] axial_step = '0, diag_step = '0, err_init = '0;
  logic [15:0] major_len = '0;
  logic [7:0]  cmd_word = '0;
  logic        pix_ready = 1'b0;
  logic        pix_valid, busy;
  logic [15:0] pix_x, pix_y, cur_x, cur_y;

  always #4 clk = ~clk;

  vec_line_engine uut (
    .clk(clk), .rst_n(rst_n), .go(go), .start_x(start_x), .start_y(start_y),
    .axial_step(axial_step), .diag_step(diag_step), .err_init(err_init),
    .major_len(major_len), .cmd_word(cmd_word), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_x(pix_x), .pix_y(pix_y), .busy(busy),
    .cur_x(cur_x), .cur_y(cur_y)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [15:0] ex_x [64];
  logic [15:0] ex_y [64];
  int          ex_n;
  logic [15:0] ex_cx, ex_cy;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // expected point list from the stepping rule of R2, R3, R4, R6, R7
  task automatic model(input logic [15:0] sx, input logic [15:0] sy,
                       input logic [17:0] ax, input logic [17:0] dg,
                       input logic [17:0] e0, input int len, input logic [7:0] cmd);
    logic [15:0] x, y;
    logic [17:0] e;
    bit emit_i, minor;
    x = sx; y = sy; e = e0; ex_n = 0;
    for (int i = 0; i < len; i++) begin
      emit_i = cmd[4] && !(cmd[2] && (i == len - 1));
      if (emit_i) begin
        ex_x[ex_n] = x; ex_y[ex_n] = y; ex_n++;
      end
      minor = !e[17];
      if (cmd[6]) begin
        y = cmd[7] ? y + 16'd1 : y - 16'd1;
        if (minor) x = cmd[5] ? x + 16'd1 : x - 16'd1;
      end else begin
        x = cmd[5] ? x + 16'd1 : x - 16'd1;
        if (minor) y = cmd[7] ? y + 16'd1 : y - 16'd1;
      end
      e = minor ? e + dg : e + ax;
    end
    ex_cx = x; ex_cy = y;
  endtask

  task automatic run_cmd(input logic [15:0] sx, input logic [15:0] sy,
                         input logic [17:0] ax, input logic [17:0] dg,
                         input logic [17:0] e0, input int len, input logic [7:0] cmd,
                         input int rdy_pct, input bit poke, input string tag);
    int idx, busy_cyc, cyc;
    bit first, prev_stall, fired_last;
    model(sx, sy, ax, dg, e0, len, cmd);
    start_x = sx; start_y = sy; axial_step = ax; diag_step = dg; err_init = e0;
    major_len = 16'(len); cmd_word = cmd; go = 1'b1;
    pix_ready = ($urandom % 100) < rdy_pct;
    @(negedge clk);
    idx = 0; busy_cyc = 0; cyc = 0; first = 1; prev_stall = 0; fired_last = 0;
    while (cyc < 5000) begin
      go = 1'b0;
      pix_ready = ($urandom % 100) < rdy_pct;
      #1;
      if (first) begin
        chk(busy == (len > 0), {"R1 busy after go ", tag}, busy, len > 0);
        chk(pix_valid == (ex_n > 0), {"R1 first valid ", tag}, pix_valid, ex_n > 0);
        if (pix_valid) begin
          chk(pix_x == sx, {"R1 first x ", tag}, pix_x, sx);
          chk(pix_y == sy, {"R1 first y ", tag}, pix_y, sy);
        end
        first = 0;
      end
      if (prev_stall) chk(pix_valid, {"R9 valid held ", tag}, pix_valid, 1);
      if (fired_last && cmd[4] && !cmd[2])
        chk(!busy, {"R10 busy after final pixel ", tag}, busy, 0);
      fired_last = 0;
      if (busy) busy_cyc++;
      if (pix_valid) begin
        if (idx < ex_n) begin
          chk(pix_x == ex_x[idx], {"R4 pixel x ", tag}, pix_x, ex_x[idx]);
          chk(pix_y == ex_y[idx], {"R4 pixel y ", tag}, pix_y, ex_y[idx]);
        end else begin
          chk(0, {"R5 extra pixel ", tag}, idx, ex_n);
        end
        prev_stall = !pix_ready;
        if (pix_ready) begin
          idx++;
          if (idx == ex_n) fired_last = 1;
        end
      end else begin
        prev_stall = 0;
      end
      if (!busy) break;
      if (poke && cyc == 2) begin
        // R10: a second go during a command must be ignored
        go = 1'b1; start_x = sx + 16'd100; start_y = sy - 16'd50;
        cmd_word = cmd ^ 8'h10; major_len = 16'(len + 3);
      end
      @(negedge clk);
      cyc++;
    end
    go = 1'b0;
    chk(idx == ex_n, {cmd[2] ? "R6 pixel count " : "R5 pixel count ", tag}, idx, ex_n);
    chk(cur_x == ex_cx, {"R8 cur_x ", tag}, cur_x, ex_cx);
    chk(cur_y == ex_cy, {"R8 cur_y ", tag}, cur_y, ex_cy);
    if (!cmd[4]) chk(busy_cyc == len, {"R7 move busy cycles ", tag}, busy_cyc, len);
  endtask

  task automatic line(input logic [15:0] sx, input logic [15:0] sy, input int dx, input int dy,
                      input bit xr, input bit yd, input bit draw, input bit nolast,
                      input int len_adj, input int rdy, input bit poke, input string tag);
    int mx, mn, len;
    bit ymaj;
    logic [17:0] ax, dg, e0;
    logic [7:0] cmd;
    ymaj = dy > dx;
    mx = ymaj ? dy : dx;
    mn = ymaj ? dx : dy;
    ax = 18'(2 * mn);
    dg = 18'(2 * (mn - mx));
    e0 = 18'(2 * mn - mx - (xr ? 1 : 0));
    len = mx + 1 + len_adj;
    if (len < 0) len = 0;
    cmd = {yd, ymaj, xr, draw, 1'b0, nolast, 2'b00};
    run_cmd(sx, sy, ax, dg, e0, len, cmd, rdy, poke, tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    chk(busy == 0, "R11 reset busy", busy, 0);
    chk(pix_valid == 0, "R11 reset valid", pix_valid, 0);
    chk(cur_x == 0 && cur_y == 0, "R11 reset cur", {cur_x, cur_y}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    line(16'd10, 16'd20, 7, 0, 1, 1, 1, 0, 0, 100, 0, "R2 x-major right");
    line(16'd50, 16'd60, 3, 9, 0, 0, 1, 0, 0, 100, 0, "R2 R3 y-major left up");
    line(16'd5, 16'd5, 5, 5, 1, 1, 1, 0, 0, 100, 0, "R3 diagonal");
    line(16'h0001, 16'h0000, 6, 4, 0, 0, 1, 0, 0, 100, 0, "R3 wrap");
    line(16'd30, 16'd40, 4, 2, 1, 1, 1, 0, -5, 100, 0, "R5 zero length");
    line(16'd30, 16'd40, 0, 0, 1, 1, 1, 1, 0, 100, 0, "R6 single suppressed");
    line(16'd100, 16'd100, 9, 4, 1, 0, 1, 1, 0, 100, 0, "R6 drop last");
    line(16'd200, 16'd300, 11, 6, 0, 1, 0, 0, 0, 50, 0, "R7 move only");
    line(16'd400, 16'd400, 3, 18, 1, 1, 1, 0, 0, 30, 1, "R9 R10 stall and poke");

    for (int n = 0; n < 40; n++) begin
      line(16'($urandom), 16'($urandom), int'($urandom % 20), int'($urandom % 20),
           1'($urandom), 1'($urandom), ($urandom % 5) != 0, ($urandom % 4) == 0,
           0, (n % 3 == 0) ? 100 : ((n % 3 == 1) ? 70 : 40), 0, "random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule